// File: doc/BRIEF.md
# Frame-Paced Segment Animation Sequencer

This block drives animated groups of LCD segments without software involvement. Each animation frame is a fixed number of indirect segment writes, delivered by an external DMA engine. When the chosen frame counter overflows, the sequencer raises a DMA request. It keeps that request up until the programmed number of write words has been accepted. Each word changes up to eight neighbouring bits of a shadow copy of the display memory, and a per-bit mask selects which of those bits change.

When the last word of a frame lands, the whole shadow is copied into the active display memory in one cycle. The panel therefore never shows a frame that is only half built. Clearing the enable bit ends any frame in progress and throws away the shadow changes that were not committed. The display memory then keeps the last committed image.

Top module: `segAnimSeq`

## Requirements
- R1: After reset, `dmaReq`, `busy` and `dispWe` are low, and both configuration registers read as zero.
- R2: Bit 0 of the control register (address 0) enables the sequencer when written 1 and disables it when written 0. While the sequencer is disabled, no overflow raises `dmaReq`.
- R3: Bits [9:8] of the configuration register (address 1) select which bit of `fcOvf` starts a frame. Only an overflow on the selected bit starts a frame while the sequencer is idle and enabled. `dmaReq` goes high in the cycle after that overflow.
- R4: Bits [7:0] of the configuration register give the frame length N, and a value of 0 means 1. N is latched when the frame starts. A write is accepted in a cycle where `dmaReq` and `dmaAck` are both high. `dmaReq` stays high, through any gaps in `dmaAck`, until exactly N writes have been accepted, and then drops.
- R5: A write word holds the data in bits [7:0], the mask in bits [15:8] and the byte offset in bits [17:16]. Only the shadow bits at positions where the mask is 1 take the new data. A mask of zero changes nothing.
- R6: In the cycle after the N-th accepted write, `dispWe` is high for exactly one cycle and `dispWdata` carries the whole shadow image. At no other time is `dispWe` high.
- R7: `busy` is high from the cycle after the starting overflow through the commit cycle, and low afterwards. It can also be read as bit 1 of the control register.
- R8: Overflows that arrive while a frame is in progress are ignored. They do not restart the write count and they do not cause an extra frame.
- R9: Writing 0 to the enable bit during a frame drops `dmaReq` and `busy` in the next cycle. The uncommitted shadow changes are discarded, so the next frame builds on the last committed image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 = control, 1 = configuration |
| cfgWdata | input | 10 | Register write data |
| cfgRdata | output | 10 | Register read data (combinational) |
| busy | output | 1 | Frame in progress |
| fcOvf | input | 4 | Overflow pulses from the frame counters |
| dmaReq | output | 1 | Request for the next write word |
| dmaAck | input | 1 | DMA word valid; accepted while `dmaReq` is high |
| dmaWdata | input | 18 | Write word: offset, mask, data |
| dispWe | output | 1 | Display memory write strobe (commit) |
| dispWdata | output | 32 | Full display image written at commit |

## Verification
The bench sweeps every frame counter select against frame lengths 0, 1, 2, 3 and 7. For each combination it first pulses a counter that is not selected, which separates correct decoding of the select field from a design that reacts to any overflow. Write words cycle through full, nibble, empty and irregular masks over all byte offsets, and the bench compares each committed image with its own model; this tells masked merging apart from plain byte overwrite and from wrong byte placement. Acknowledge gaps with overflow storms placed inside frames, together with an aborted frame followed by a short frame, distinguish a held request and a latched length from a request that restarts or stops early, and distinguish discarded shadow changes from leaked ones.

// File: rtl/segAnimPkg.sv
package segAnimPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_COMMIT = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;  // apply the current DMA word to the shadow
    logic commit;    // copy shadow into display memory
    logic restore;   // reload shadow from the committed image
  } ctlStrobes_t;

endpackage

// File: rtl/segAnimRegs.sv
module segAnimRegs #(
  parameter int SIZE_W = 8,
  parameter int FCS_W  = 2,
  localparam int CFG_W = SIZE_W + FCS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             busy,
  output logic             enable,
  output logic [SIZE_W-1:0] frameSize,
  output logic [FCS_W-1:0]  fcSel
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      frameSize <= '0;
      fcSel     <= '0;
    end else if (cfgWe) begin
      if (cfgAddr == 1'b0) begin
        enable <= cfgWdata[0];
      end else begin
        frameSize <= cfgWdata[SIZE_W-1:0];
        fcSel     <= cfgWdata[CFG_W-1:SIZE_W];
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (cfgAddr == 1'b0) begin
      cfgRdata[0] = enable;
      cfgRdata[1] = busy;
    end else begin
      cfgRdata = {fcSel, frameSize};
    end
  end

endmodule

// File: rtl/segAnimCtrl.sv
module segAnimCtrl
  import segAnimPkg::*;
#(
  parameter int NUM_FC = 4,
  parameter int SIZE_W = 8,
  localparam int FCS_W = $clog2(NUM_FC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SIZE_W-1:0] frameSize,
  input  logic [FCS_W-1:0]  fcSel,
  input  logic [NUM_FC-1:0] fcOvf,
  input  logic              dmaAck,
  output logic              dmaReq,
  output logic              busy,
  output ctlStrobes_t       strb
);

  seqState_t         state;
  logic [SIZE_W-1:0] wrCount;
  logic [SIZE_W-1:0] target;
  logic              accept;
  logic              lastWrite;

  assign dmaReq    = enable && (state == ST_XFER);
  assign busy      = enable && (state != ST_IDLE);
  assign accept    = dmaReq && dmaAck;
  assign lastWrite = accept && (wrCount == target - SIZE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrCount <= '0;
      target  <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      wrCount <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fcOvf[fcSel]) begin
            state   <= ST_XFER;
            wrCount <= '0;
            target  <= (frameSize == '0) ? SIZE_W'(1) : frameSize;
          end
        end
        ST_XFER: begin
          if (accept) begin
            wrCount <= wrCount + SIZE_W'(1);
            if (lastWrite) state <= ST_COMMIT;
          end
        end
        default: begin
          state   <= ST_IDLE;
          wrCount <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrStrobe = accept;
    strb.commit   = enable && (state == ST_COMMIT);
    strb.restore  = !enable;
  end

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> enable); // R2
  AST_ACCEPT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (wrCount < target)); // R4
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (!strb.commit && !busy)); // R7
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commit) |=> $stable(target)); // R8

endmodule

// File: rtl/segAnimData.sv
module segAnimData
  import segAnimPkg::*;
#(
  parameter int MEM_BYTES = 4,
  localparam int OFF_W  = $clog2(MEM_BYTES),
  localparam int MEM_W  = MEM_BYTES * 8,
  localparam int WORD_W = 16 + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [WORD_W-1:0] dmaWdata,
  output logic              dispWe,
  output logic [MEM_W-1:0]  dispWdata
);

  logic [MEM_W-1:0] shadow;
  logic [MEM_W-1:0] committed;
  logic [MEM_W-1:0] shadowNext;
  logic [7:0]       wrData;
  logic [7:0]       wrMask;
  logic [OFF_W-1:0] wrOff;

  assign wrData = dmaWdata[7:0];
  assign wrMask = dmaWdata[15:8];
  assign wrOff  = dmaWdata[WORD_W-1:16];

  for (genvar b = 0; b < MEM_BYTES; b++) begin : g_byte
    always_comb begin
      shadowNext[b*8 +: 8] = shadow[b*8 +: 8];
      if (strb.restore) begin
        shadowNext[b*8 +: 8] = committed[b*8 +: 8];
      end else if (strb.wrStrobe && (wrOff == OFF_W'(b))) begin
        shadowNext[b*8 +: 8] = (shadow[b*8 +: 8] & ~wrMask) | (wrData & wrMask);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow    <= '0;
      committed <= '0;
    end else begin
      shadow <= shadowNext;
      if (strb.commit) committed <= shadow;
    end
  end

  assign dispWe    = strb.commit;
  assign dispWdata = shadow;

  AST_MASK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStrobe && (wrMask == 8'h00)) |=> $stable(shadow)); // R5
  AST_DISP_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(committed)); // R6
  AST_RESTORE_DISCARDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.restore |=> (shadow == $past(committed))); // R9

endmodule

// File: rtl/segAnimSeq.sv
module segAnimSeq
  import segAnimPkg::*;
#(
  parameter int NUM_FC    = 4,
  parameter int MEM_BYTES = 4,
  parameter int SIZE_W    = 8,
  localparam int FCS_W  = $clog2(NUM_FC),
  localparam int OFF_W  = $clog2(MEM_BYTES),
  localparam int MEM_W  = MEM_BYTES * 8,
  localparam int WORD_W = 16 + OFF_W,
  localparam int CFG_W  = SIZE_W + FCS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  output logic              busy,
  input  logic [NUM_FC-1:0] fcOvf,
  output logic              dmaReq,
  input  logic              dmaAck,
  input  logic [WORD_W-1:0] dmaWdata,
  output logic              dispWe,
  output logic [MEM_W-1:0]  dispWdata
);

  logic              enable;
  logic [SIZE_W-1:0] frameSize;
  logic [FCS_W-1:0]  fcSel;
  ctlStrobes_t       strb;

  segAnimRegs #(.SIZE_W(SIZE_W), .FCS_W(FCS_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .busy(busy),
    .enable(enable), .frameSize(frameSize), .fcSel(fcSel)
  );

  segAnimCtrl #(.NUM_FC(NUM_FC), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .frameSize(frameSize),
    .fcSel(fcSel), .fcOvf(fcOvf), .dmaAck(dmaAck), .dmaReq(dmaReq),
    .busy(busy), .strb(strb)
  );

  segAnimData #(.MEM_BYTES(MEM_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dmaWdata(dmaWdata),
    .dispWe(dispWe), .dispWdata(dispWdata)
  );

endmodule

// File: tb/segAnimSeq_tb.sv
module segAnimSeq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgAddr = 1'b0;
  logic [9:0]  cfgWdata = '0;
  logic [9:0]  cfgRdata;
  logic        busy;
  logic [3:0]  fcOvf = '0;
  logic        dmaReq;
  logic        dmaAck = 1'b0;
  logic [17:0] dmaWdata = '0;
  logic        dispWe;
  logic [31:0] dispWdata;

  int tests = 0;
  int fails = 0;
  logic [31:0] modelCommitted = '0;
  logic [31:0] modelShadow = '0;

  always #2 clk = ~clk;

  segAnimSeq u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .busy(busy), .fcOvf(fcOvf),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .dmaWdata(dmaWdata),
    .dispWe(dispWe), .dispWdata(dispWdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic addr, input logic [9:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = val;
    @(negedge clk);
    cfgWe = 1'b0; cfgAddr = 1'b0;
  endtask

  task automatic pulseOvf(input int idx);
    @(negedge clk);
    fcOvf = 4'(1 << idx);
    @(negedge clk);
    fcOvf = '0;
  endtask

  function automatic logic [17:0] mkWord(input int seed, input int i);
    logic [7:0] d, m;
    logic [1:0] o;
    o = 2'((seed + i * 3) % 4);
    d = 8'((seed * 29 + i * 53 + 7) & 255);
    case (i % 4)
      0: m = 8'hFF;
      1: m = 8'h0F;
      2: m = 8'h00;
      default: m = 8'((seed * 13 + i) & 255);
    endcase
    return {o, m, d};
  endfunction

  function automatic logic [31:0] applyWord(input logic [31:0] img, input logic [17:0] w);
    logic [31:0] r;
    int o;
    r = img;
    o = int'(w[17:16]);
    r[o*8 +: 8] = (img[o*8 +: 8] & ~w[15:8]) | (w[7:0] & w[15:8]);
    return r;
  endfunction

  // Starts after pulseOvf returned (request should be up at this negedge)
  task automatic runFrame(input int n, input int seed, input bit gaps);
    logic [17:0] w;
    modelShadow = modelCommitted;
    check(dmaReq === 1'b1, "R3 req after selected overflow", 32'(dmaReq), 1);
    check(busy === 1'b1, "R7 busy at frame start", 32'(busy), 1);
    check(cfgRdata[1:0] === 2'b11, "R7 busy readback", 32'(cfgRdata), 3);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        fcOvf = 4'hF;
        @(negedge clk);
        fcOvf = '0;
        check(dmaReq === 1'b1, "R8 req held through gap/overflow", 32'(dmaReq), 1);
      end
      check(dmaReq === 1'b1 && dispWe === 1'b0, "R4 req held before last write",
            {30'd0, dmaReq, dispWe}, 32'h2);
      w = mkWord(seed, i);
      dmaAck = 1'b1; dmaWdata = w;
      modelShadow = applyWord(modelShadow, w);
      @(negedge clk);
      dmaAck = 1'b0;
    end
    check(dmaReq === 1'b0, "R4 req drops after N writes", 32'(dmaReq), 0);
    check(dispWe === 1'b1, "R6 commit strobe", 32'(dispWe), 1);
    check(dispWdata === modelShadow, "R5 committed image", dispWdata, modelShadow);
    check(busy === 1'b1, "R7 busy in commit cycle", 32'(busy), 1);
    modelCommitted = modelShadow;
    @(negedge clk);
    check(dispWe === 1'b0 && busy === 1'b0, "R7 idle after commit",
          {30'd0, dispWe, busy}, 0);
    @(negedge clk);
    check(dmaReq === 1'b0 && dispWe === 1'b0, "R8 no extra frame",
          {30'd0, dmaReq, dispWe}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int sizes[5] = '{0, 1, 2, 3, 7};
    int seed = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dmaReq === 0 && busy === 0 && dispWe === 0, "R1 outputs after reset",
          {29'd0, dmaReq, busy, dispWe}, 0);
    check(cfgRdata === 10'd0, "R1 control reg", 32'(cfgRdata), 0);
    cfgAddr = 1'b1; #0.1;
    check(cfgRdata === 10'd0, "R1 config reg", 32'(cfgRdata), 0);
    cfgAddr = 1'b0;

    // R2 disabled: overflow ignored
    cfgWrite(1'b1, {2'd0, 8'd2});
    pulseOvf(0);
    check(dmaReq === 1'b0 && busy === 1'b0, "R2 no req while disabled",
          {30'd0, dmaReq, busy}, 0);
    cfgWrite(1'b0, 10'd1);
    check(cfgRdata[0] === 1'b1, "R2 enable readback", 32'(cfgRdata), 1);

    // Sweep selects and sizes
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 5; s++) begin
        cfgWrite(1'b1, {2'(f), 8'(sizes[s])});
        cfgAddr = 1'b1; #0.1;
        check(cfgRdata === {2'(f), 8'(sizes[s])}, "R4 config readback",
              32'(cfgRdata), {22'd0, 2'(f), 8'(sizes[s])});
        cfgAddr = 1'b0;
        pulseOvf((f + 1) % 4);
        check(dmaReq === 1'b0, "R3 unselected overflow ignored", 32'(dmaReq), 0);
        pulseOvf(f);
        runFrame((sizes[s] == 0) ? 1 : sizes[s], seed, (s % 2) == 0);
        seed++;
      end
    end

    // R9 abort mid-frame, then a short frame builds on committed image
    cfgWrite(1'b1, {2'd3, 8'd4});
    pulseOvf(3);
    for (int i = 0; i < 2; i++) begin
      dmaAck = 1'b1; dmaWdata = {2'(i), 8'hFF, 8'h5A};
      @(negedge clk);
      dmaAck = 1'b0;
      check(dispWe === 1'b0, "R6 no commit mid-frame", 32'(dispWe), 0);
    end
    cfgWrite(1'b0, 10'd0);
    check(dmaReq === 1'b0 && busy === 1'b0, "R9 abort drops req and busy",
          {30'd0, dmaReq, busy}, 0);
    cfgWrite(1'b0, 10'd1);
    cfgWrite(1'b1, {2'd3, 8'd1});
    pulseOvf(3);
    runFrame(1, 77, 1'b0);
    check(dispWdata === modelCommitted, "R9 aborted changes discarded",
          dispWdata, modelCommitted);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule